// File: doc/BRIEF.md
# Key-Protected Flash Control Register Interface

This block is the software-facing register front end of a flash memory controller. It holds three 16-bit control registers on a simple peripheral bus. The first register holds the erase and program mode bits. The second holds the timing-clock source select and divider. The third holds the lock, emergency-exit and status bits.

Every write must carry the key byte 0xA5 in bits 15:8. A write without it is discarded, latches a key-fault flag and raises a one-cycle system reset request. Reads always show the signature byte 0x96 in bits 15:8. The block also polices writes against the live BUSY and WAIT state of the flash sequencer. An illegal write is dropped and latches a sticky access-fault flag. That flag drives a non-maskable interrupt request, gated only by its own enable.

The write path is watched by a small guard state machine with three states:
- `ST_IDLE`: nothing pending.
- `ST_KEY_FAULT`: drives the reset request for one cycle.
- `ST_ACC_FAULT`: sets the access-fault flag.

Its transitions are:
- `key_miss`: any state goes to `ST_KEY_FAULT` on a badly keyed write.
- `rule_break`: any state goes to `ST_ACC_FAULT` on a well keyed write that breaks a busy rule.
- `settle`: any state goes to `ST_IDLE` on every other cycle.

Top module: `flash_ctl_regs`

## Requirements
- R1: A word write to a mapped register whose bits 15:8 differ from 0xA5 leaves all registers unchanged, sets the key-fault flag (control 3 bit 1), and makes `puc_req` high for exactly the one cycle after the write edge.
- R2: A byte write (`bus_byte`=1) to a mapped register is always treated as a key fault, whatever its data.
- R3: A read of offset 0x128, 0x12A or 0x12C returns 0x96 in bits 15:8. A read of any other address returns 0x0000.
- R4: After reset, control 1 reads 0x9600 and control 2 reads 0x9642. Control 3 reads 0x9618 while WAIT is high and BUSY is low.
- R5: Control 3 bits are BUSY=0, key fault=1, access fault=2, WAIT=3, LOCK=4, EMEX=5. Bits 0 and 3 always mirror the sequencer inputs, and writes to them have no effect.
- R6: While BUSY=1, a control 1 write is an access fault unless the stored block-write bit (control 1 bit 7) is set and WAIT=1. A faulting write is discarded.
- R7: A control 2 write while BUSY=1 is an access fault and is discarded.
- R8: Reads of any register while BUSY=1, and well keyed control 3 writes, never raise an access fault.
- R9: The access-fault flag is set in the second cycle after a faulting write. It stays set until a well keyed control 3 write has bit 2 clear.
- R10: `irq` equals the access-fault flag ANDed with `accv_ie`, delayed by one register.
- R11: Control 1 holds segment-erase (bit 1), mass-erase (bit 2), word-write (bit 6) and block-write (bit 7). These drive `erase_en`, `mass_en`, `wrt_en` and `blk_en` while LOCK=0, and all four are low while LOCK=1. Control 2 bits 7:6 drive `clk_sel` and bits 5:0 drive `clk_div`.
- R12: A well keyed control 3 write with bit 5 set clears the whole low byte of control 1 at the same edge and drives `emex` high.
- R13: A falling edge of BUSY clears control 1 bits 1 and 2. A steady BUSY level leaves them unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_sel | input | 1 | Bus access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_byte | input | 1 | 1 = byte access, 0 = word access |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 16 | Write data, key in bits 15:8 |
| bus_rdata | output | 16 | Read data, signature in bits 15:8 |
| seq_busy | input | 1 | Sequencer operation in progress |
| seq_wait | input | 1 | Sequencer ready for next block word |
| accv_ie | input | 1 | Access-fault interrupt enable |
| puc_req | output | 1 | System reset request after a key fault |
| irq | output | 1 | Access-fault interrupt request |
| erase_en | output | 1 | Segment erase mode |
| mass_en | output | 1 | Mass erase mode |
| wrt_en | output | 1 | Word/byte write mode |
| blk_en | output | 1 | Block write mode |
| clk_sel | output | 2 | Timing clock source select |
| clk_div | output | 6 | Timing clock divider |
| lock | output | 1 | Lock bit |
| emex | output | 1 | Emergency exit bit |

## Verification
The properties assume that BUSY and WAIT come from a well-behaved sequencer. They must be stable within a cycle and must change only between bus accesses. The properties also assume that a bus access lasts exactly one cycle. The bench keeps to this: it changes BUSY and WAIT only while `bus_sel` is low, and holds every access for a single clock. Its sweeps cover all 256 key bytes, and every BUSY, WAIT and block-mode combination for control 1 writes.

// File: rtl/flash_ctl_pkg.sv
package flash_ctl_pkg;

    localparam int DATA_W = 16;
    localparam int HALF_W = DATA_W / 2;

    localparam int C1_ERASE = 1;
    localparam int C1_MASS  = 2;
    localparam int C1_WRT   = 6;
    localparam int C1_BLK   = 7;

    localparam int C3_BUSY  = 0;
    localparam int C3_KEYV  = 1;
    localparam int C3_ACCV  = 2;
    localparam int C3_WAIT  = 3;
    localparam int C3_LOCK  = 4;
    localparam int C3_EMEX  = 5;

    typedef enum logic [1:0] {
        ST_IDLE      = 2'd0,
        ST_KEY_FAULT = 2'd1,
        ST_ACC_FAULT = 2'd2
    } guard_state_e;

    typedef enum logic [1:0] {
        SEL_NONE = 2'd0,
        SEL_C1   = 2'd1,
        SEL_C2   = 2'd2,
        SEL_C3   = 2'd3
    } reg_sel_e;

endpackage

// File: rtl/flash_key_guard.sv
module flash_key_guard
    import flash_ctl_pkg::*;
#(
    parameter int               ADDR_W  = 9,
    parameter logic [ADDR_W-1:0] C1_OFS = 9'h128,
    parameter logic [ADDR_W-1:0] C2_OFS = 9'h12A,
    parameter logic [ADDR_W-1:0] C3_OFS = 9'h12C,
    parameter logic [HALF_W-1:0] KEY_VAL = 8'hA5
) (
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic              bus_byte,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [HALF_W-1:0] key_in,
    output reg_sel_e          sel_hit,
    output logic              rd_hit,
    output logic              wr_ok,
    output logic              wr_bad
);

    logic mapped;

    always_comb begin
        if (bus_addr == C1_OFS) begin
            sel_hit = SEL_C1;
        end else if (bus_addr == C2_OFS) begin
            sel_hit = SEL_C2;
        end else if (bus_addr == C3_OFS) begin
            sel_hit = SEL_C3;
        end else begin
            sel_hit = SEL_NONE;
        end
    end

    assign mapped = bus_sel && (sel_hit != SEL_NONE);
    assign rd_hit = mapped && !bus_wr;
    assign wr_ok  = mapped && bus_wr && !bus_byte && (key_in == KEY_VAL);
    assign wr_bad = mapped && bus_wr && !wr_ok;

endmodule

// File: rtl/flash_access_rules.sv
module flash_access_rules
    import flash_ctl_pkg::*;
(
    input  reg_sel_e sel_hit,
    input  logic     wr_ok,
    input  logic     seq_busy,
    input  logic     seq_wait,
    input  logic     blk_mode,
    output logic     viol,
    output logic     commit
);

    logic c1_block;
    logic c2_block;

    always_comb begin
        c1_block = 1'b0;
        c2_block = 1'b0;
        if (seq_busy) begin
            c1_block = !(blk_mode && seq_wait);
            c2_block = 1'b1;
        end
    end

    always_comb begin
        viol = 1'b0;
        if (wr_ok) begin
            unique case (sel_hit)
                SEL_C1:   viol = c1_block;
                SEL_C2:   viol = c2_block;
                SEL_C3:   viol = 1'b0;
                SEL_NONE: viol = 1'b0;
            endcase
        end
    end

    assign commit = wr_ok && !viol;

endmodule

// File: rtl/flash_guard_fsm.sv
module flash_guard_fsm
    import flash_ctl_pkg::*;
(
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_bad,
    input  logic         viol,
    output guard_state_e state,
    output logic         puc_req,
    output logic         accv_set
);

    guard_state_e state_nxt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= state_nxt;
        end
    end

    always_comb begin
        state_nxt = ST_IDLE;
        unique case (state)
            ST_IDLE, ST_KEY_FAULT, ST_ACC_FAULT: begin
                if (wr_bad) begin
                    state_nxt = ST_KEY_FAULT;
                end else if (viol) begin
                    state_nxt = ST_ACC_FAULT;
                end else begin
                    state_nxt = ST_IDLE;
                end
            end
            default: state_nxt = ST_IDLE;
        endcase
    end

    always_comb begin
        puc_req  = 1'b0;
        accv_set = 1'b0;
        unique case (state)
            ST_IDLE:      ;
            ST_KEY_FAULT: puc_req  = 1'b1;
            ST_ACC_FAULT: accv_set = 1'b1;
            default:      ;
        endcase
    end

endmodule

// File: rtl/flash_ctl_regfile.sv
module flash_ctl_regfile
    import flash_ctl_pkg::*;
#(
    parameter logic [HALF_W-1:0] C1_RST = 8'h00,
    parameter logic [HALF_W-1:0] C2_RST = 8'h42,
    parameter logic [HALF_W-1:0] C3_RST = 8'h10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  reg_sel_e          sel_hit,
    input  logic              commit,
    input  logic [HALF_W-1:0] wdata_lo,
    input  logic              key_set,
    input  logic              accv_set,
    input  logic              busy_fall,
    input  logic              seq_busy,
    input  logic              seq_wait,
    output logic [HALF_W-1:0] c1_q,
    output logic [HALF_W-1:0] c2_q,
    output logic [HALF_W-1:0] c3_view,
    output logic              accvifg
);

    logic [HALF_W-1:0] c3_q;
    logic [HALF_W-1:0] c1_nxt;
    logic [HALF_W-1:0] c2_nxt;
    logic [HALF_W-1:0] c3_nxt;

    always_comb begin
        c1_nxt = c1_q;
        c2_nxt = c2_q;
        c3_nxt = c3_q;
        if (commit && sel_hit == SEL_C1) begin
            c1_nxt = wdata_lo;
        end
        if (commit && sel_hit == SEL_C2) begin
            c2_nxt = wdata_lo;
        end
        if (busy_fall) begin
            c1_nxt[C1_ERASE] = 1'b0;
            c1_nxt[C1_MASS]  = 1'b0;
        end
        if (commit && sel_hit == SEL_C3) begin
            c3_nxt = wdata_lo;
            if (wdata_lo[C3_EMEX]) begin
                c1_nxt = '0;
            end
        end
        if (key_set) begin
            c3_nxt[C3_KEYV] = 1'b1;
        end
        if (accv_set) begin
            c3_nxt[C3_ACCV] = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            c1_q <= C1_RST;
            c2_q <= C2_RST;
            c3_q <= C3_RST;
        end else begin
            c1_q <= c1_nxt;
            c2_q <= c2_nxt;
            c3_q <= c3_nxt;
        end
    end

    always_comb begin
        c3_view          = c3_q;
        c3_view[C3_BUSY] = seq_busy;
        c3_view[C3_WAIT] = seq_wait;
    end

    assign accvifg = c3_q[C3_ACCV];

endmodule

// File: rtl/flash_ctl_regs.sv
module flash_ctl_regs
    import flash_ctl_pkg::*;
#(
    parameter int                ADDR_W  = 9,
    parameter logic [ADDR_W-1:0] C1_OFS  = 9'h128,
    parameter logic [ADDR_W-1:0] C2_OFS  = 9'h12A,
    parameter logic [ADDR_W-1:0] C3_OFS  = 9'h12C,
    parameter logic [7:0]        KEY_VAL = 8'hA5,
    parameter logic [7:0]        SIG_VAL = 8'h96
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic              bus_byte,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [15:0]       bus_wdata,
    output logic [15:0]       bus_rdata,
    input  logic              seq_busy,
    input  logic              seq_wait,
    input  logic              accv_ie,
    output logic              puc_req,
    output logic              irq,
    output logic              erase_en,
    output logic              mass_en,
    output logic              wrt_en,
    output logic              blk_en,
    output logic [1:0]        clk_sel,
    output logic [5:0]        clk_div,
    output logic              lock,
    output logic              emex
);

    localparam int SEL_W = 2;
    localparam int DIV_W = HALF_W - SEL_W;

    reg_sel_e          sel_hit;
    guard_state_e      state;
    logic              rd_hit;
    logic              wr_ok;
    logic              wr_bad;
    logic              viol;
    logic              commit;
    logic              accv_set;
    logic              accvifg;
    logic              busy_q;
    logic              busy_fall;
    logic [HALF_W-1:0] c1_q;
    logic [HALF_W-1:0] c2_q;
    logic [HALF_W-1:0] c3_view;

    flash_key_guard #(
        .ADDR_W (ADDR_W),
        .C1_OFS (C1_OFS),
        .C2_OFS (C2_OFS),
        .C3_OFS (C3_OFS),
        .KEY_VAL(KEY_VAL)
    ) u_key (
        .bus_sel (bus_sel),
        .bus_wr  (bus_wr),
        .bus_byte(bus_byte),
        .bus_addr(bus_addr),
        .key_in  (bus_wdata[DATA_W-1:HALF_W]),
        .sel_hit (sel_hit),
        .rd_hit  (rd_hit),
        .wr_ok   (wr_ok),
        .wr_bad  (wr_bad)
    );

    flash_access_rules u_rules (
        .sel_hit (sel_hit),
        .wr_ok   (wr_ok),
        .seq_busy(seq_busy),
        .seq_wait(seq_wait),
        .blk_mode(c1_q[C1_BLK]),
        .viol    (viol),
        .commit  (commit)
    );

    flash_guard_fsm u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_bad  (wr_bad),
        .viol    (viol),
        .state   (state),
        .puc_req (puc_req),
        .accv_set(accv_set)
    );

    flash_ctl_regfile u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .sel_hit  (sel_hit),
        .commit   (commit),
        .wdata_lo (bus_wdata[HALF_W-1:0]),
        .key_set  (wr_bad),
        .accv_set (accv_set),
        .busy_fall(busy_fall),
        .seq_busy (seq_busy),
        .seq_wait (seq_wait),
        .c1_q     (c1_q),
        .c2_q     (c2_q),
        .c3_view  (c3_view),
        .accvifg  (accvifg)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
            irq    <= 1'b0;
        end else begin
            busy_q <= seq_busy;
            irq    <= accvifg && accv_ie;
        end
    end

    assign busy_fall = busy_q && !seq_busy;

    always_comb begin
        bus_rdata = '0;
        if (rd_hit) begin
            unique case (sel_hit)
                SEL_C1:   bus_rdata = {SIG_VAL, c1_q};
                SEL_C2:   bus_rdata = {SIG_VAL, c2_q};
                SEL_C3:   bus_rdata = {SIG_VAL, c3_view};
                SEL_NONE: bus_rdata = '0;
            endcase
        end
    end

    assign lock     = c3_view[C3_LOCK];
    assign emex     = c3_view[C3_EMEX];
    assign erase_en = c1_q[C1_ERASE] && !lock;
    assign mass_en  = c1_q[C1_MASS]  && !lock;
    assign wrt_en   = c1_q[C1_WRT]   && !lock;
    assign blk_en   = c1_q[C1_BLK]   && !lock;
    assign clk_sel  = c2_q[HALF_W-1:DIV_W];
    assign clk_div  = c2_q[DIV_W-1:0];

endmodule

// File: rtl/flash_ctl_regs_chk.sv
module flash_ctl_regs_chk
    import flash_ctl_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              rd_hit,
    input logic [15:0]       bus_rdata,
    input logic [15:0]       bus_wdata,
    input reg_sel_e          sel_hit,
    input logic              wr_ok,
    input logic              wr_bad,
    input logic              seq_busy,
    input logic              puc_req,
    input logic              accvifg,
    input logic              accv_ie,
    input logic              irq,
    input logic              lock,
    input logic              erase_en,
    input logic              mass_en,
    input logic              wrt_en,
    input logic              blk_en,
    input logic [HALF_W-1:0] c1_q
);

    // R1
    key_fault_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_bad |=> puc_req);

    // R3
    read_signature_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_hit |-> (bus_rdata[15:8] == 8'h96));

    // R7
    c2_busy_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ok && sel_hit == SEL_C2 && seq_busy) |=> ##1 accvifg);

    // R9
    accv_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (accvifg && !(wr_ok && sel_hit == SEL_C3 && !bus_wdata[2])) |=> accvifg);

    // R10
    irq_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (irq == $past(accvifg && accv_ie)));

    // R11
    lock_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lock |-> !(erase_en || mass_en || wrt_en || blk_en));

    // R12
    emex_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ok && sel_hit == SEL_C3 && bus_wdata[5]) |=> (c1_q == '0));

endmodule

bind flash_ctl_regs flash_ctl_regs_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .rd_hit   (rd_hit),
    .bus_rdata(bus_rdata),
    .bus_wdata(bus_wdata),
    .sel_hit  (sel_hit),
    .wr_ok    (wr_ok),
    .wr_bad   (wr_bad),
    .seq_busy (seq_busy),
    .puc_req  (puc_req),
    .accvifg  (accvifg),
    .accv_ie  (accv_ie),
    .irq      (irq),
    .lock     (lock),
    .erase_en (erase_en),
    .mass_en  (mass_en),
    .wrt_en   (wrt_en),
    .blk_en   (blk_en),
    .c1_q     (c1_q)
);

// File: tb/flash_ctl_regs_test.sv
module flash_ctl_regs_test;

    localparam logic [8:0] A1 = 9'h128;
    localparam logic [8:0] A2 = 9'h12A;
    localparam logic [8:0] A3 = 9'h12C;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic        bus_byte = 1'b0;
    logic [8:0]  bus_addr = '0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic        seq_busy = 1'b0;
    logic        seq_wait = 1'b1;
    logic        accv_ie = 1'b0;
    logic        puc_req, irq, erase_en, mass_en, wrt_en, blk_en, lock, emex;
    logic [1:0]  clk_sel;
    logic [5:0]  clk_div;

    int checks = 0;
    int errors = 0;
    logic [15:0] rd_val;

    always #10 clk = ~clk;

    flash_ctl_regs uut (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_byte(bus_byte), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .seq_busy(seq_busy), .seq_wait(seq_wait),
        .accv_ie(accv_ie), .puc_req(puc_req), .irq(irq), .erase_en(erase_en),
        .mass_en(mass_en), .wrt_en(wrt_en), .blk_en(blk_en), .clk_sel(clk_sel),
        .clk_div(clk_div), .lock(lock), .emex(emex)
    );

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [8:0] a, input logic [15:0] d, input logic byt);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_byte = byt; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0; bus_byte = 1'b0;
    endtask

    task automatic rd(input logic [8:0] a);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        #2 rd_val = bus_rdata;
        @(negedge clk);
        bus_sel = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual hung expected done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [7:0] exp2;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R4 reset values
        rd(A1); check("R4 c1 reset", rd_val, 16'h9600);
        rd(A2); check("R4 c2 reset", rd_val, 16'h9642);
        rd(A3); check("R4 c3 reset", rd_val, 16'h9618);
        check("R4 puc idle", {15'd0, puc_req}, 16'd0);
        // R3 unmapped
        rd(9'h12E); check("R3 unmapped", rd_val, 16'h0000);

        // R1 key sweep over all upper bytes on control 2
        exp2 = 8'h42;
        for (int k = 0; k < 256; k++) begin
            wr(A2, {k[7:0], k[7:0] ^ 8'h3C}, 1'b0);
            check("R1 puc pulse", {15'd0, puc_req}, {15'd0, (k != 8'hA5)});
            if (k == 8'hA5) exp2 = k[7:0] ^ 8'h3C;
            rd(A2);
            check("R1 c2 value", rd_val, {8'h96, exp2});
            check("R1 puc single", {15'd0, puc_req}, 16'd0);
        end
        rd(A3); check("R1 keyv set", rd_val & 16'h0002, 16'h0002);
        wr(A3, 16'hA500, 1'b0);
        rd(A3); check("R5 c3 cleared", rd_val, 16'h9608);

        // R2 byte write with correct key
        wr(A2, 16'hA511, 1'b1);
        check("R2 byte puc", {15'd0, puc_req}, 16'd1);
        rd(A2); check("R2 c2 kept", rd_val, {8'h96, exp2});
        // R5 mirror bits not writable
        wr(A3, 16'hA509, 1'b0);
        rd(A3); check("R5 mirror ignore", rd_val, 16'h9608);
        seq_wait = 1'b0; idle(1);
        rd(A3); check("R5 wait mirror", rd_val, 16'h9600);
        seq_wait = 1'b1;

        // R6 busy/wait/block sweep on control 1
        for (int b = 0; b < 2; b++) begin
            for (int w = 0; w < 2; w++) begin
                for (int m = 0; m < 2; m++) begin
                    logic v;
                    logic [7:0] orig;
                    seq_busy = 1'b0; seq_wait = 1'b1; idle(1);
                    wr(A3, 16'hA500, 1'b0);
                    orig = (m != 0) ? 8'hC0 : 8'h40;
                    wr(A1, {8'hA5, orig}, 1'b0);
                    seq_busy = b[0]; seq_wait = w[0]; idle(1);
                    wr(A1, 16'hA541, 1'b0);
                    v = b[0] && (m == 0 || w == 0);
                    rd(A3);
                    check("R6 c3 after write", rd_val,
                          {8'h96, 4'b0000, w[0], v, 1'b0, b[0]});
                    rd(A1);
                    check("R6 c1 after write", rd_val, {8'h96, v ? orig : 8'h41});
                    rd(A3);
                    check("R8 busy read no fault", rd_val & 16'h0004, {13'd0, v, 2'b00});
                end
            end
        end
        seq_busy = 1'b0; seq_wait = 1'b1; idle(1);

        // R7 control 2 busy
        wr(A3, 16'hA500, 1'b0);
        seq_busy = 1'b1; idle(1);
        wr(A2, 16'hA517, 1'b0);
        rd(A2); check("R7 c2 kept", rd_val, {8'h96, exp2});
        rd(A3); check("R7 fault set", rd_val & 16'h0004, 16'h0004);
        // R9 sticky across other writes
        wr(A3, 16'hA504, 1'b0);
        rd(A3); check("R9 set kept", rd_val & 16'h0004, 16'h0004);
        // R10 irq
        accv_ie = 1'b1; idle(2);
        check("R10 irq on", {15'd0, irq}, 16'd1);
        accv_ie = 1'b0; idle(2);
        check("R10 irq gated", {15'd0, irq}, 16'd0);
        accv_ie = 1'b1;
        wr(A3, 16'hA500, 1'b0);
        rd(A3); check("R8 R9 c3 write clears", rd_val, 16'h9609);
        idle(2);
        check("R10 irq off", {15'd0, irq}, 16'd0);
        accv_ie = 1'b0;
        seq_busy = 1'b0; idle(1);

        // R11 lock gating and clock fields
        wr(A2, 16'hA585, 1'b0);
        check("R11 clk_sel", {14'd0, clk_sel}, 16'd2);
        check("R11 clk_div", {10'd0, clk_div}, 16'd5);
        wr(A3, 16'hA510, 1'b0);
        wr(A1, 16'hA5C6, 1'b0);
        check("R11 locked", {12'd0, erase_en, mass_en, wrt_en, blk_en}, 16'h0000);
        rd(A1); check("R11 c1 stored", rd_val, 16'h96C6);
        wr(A3, 16'hA500, 1'b0);
        check("R11 unlocked", {12'd0, erase_en, mass_en, wrt_en, blk_en}, 16'h000F);

        // R12 emergency exit
        wr(A3, 16'hA520, 1'b0);
        check("R12 emex", {15'd0, emex}, 16'd1);
        rd(A1); check("R12 c1 cleared", rd_val, 16'h9600);

        // R13 busy fall clears erase bits
        wr(A3, 16'hA500, 1'b0);
        wr(A1, 16'hA546, 1'b0);
        seq_busy = 1'b1; idle(2);
        rd(A1); check("R13 steady busy", rd_val, 16'h9646);
        seq_busy = 1'b0; idle(2);
        rd(A1); check("R13 fall clears", rd_val, 16'h9640);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule